// File: doc/BRIEF.md
# Display-ID Transmit-Only Serializer

This block streams a 128-byte identification table onto a shared serial data line with no host addressing. An external transmit clock paces the stream. The block brings that clock into the fast system clock domain through a two-flop synchronizer and acts on its rising edges. On each rising edge it presents one new bit on an open-drain style output. The output is a data value plus an output-enable, and the line reads high whenever the enable is low.

After reset, a fixed window of transmit-clock edges is used only for internal alignment, and the line stays released during it. After that window the block sends each byte as eight data bits, most significant bit first, and follows each byte with a released null slot. The byte pointer steps through the table and wraps from the last address back to zero. The next byte is read from a synchronous table port during the null slot.

A mode arbiter drives `enable_i`. While it is low, the line is released and all progress is frozen. Streaming picks up again exactly where it stopped.

Top module: `id_tx_serializer`

## Requirements
- R1: After reset `sda_oe_o` is 0 and `sda_o` is 1. The first 9 enabled rising edges of `tclk_i` leave `sda_oe_o` at 0.
- R2: The 10th enabled rising edge drives bit 7 of the byte at address 0.
- R3: Outputs change only in response to an enabled rising edge of `tclk_i`, or to `enable_i` going low. They settle within 3 system clocks of the edge.
- R4: A data bit is sent with `sda_oe_o`=1 and `sda_o` equal to the bit. Each byte's eight bits go out from bit 7 down to bit 0.
- R5: The ninth slot after each byte is a null bit, sent with `sda_oe_o`=0 and `sda_o`=1.
- R6: Bytes are sent from consecutive addresses. After address 127 the stream continues at address 0 with no gap or extra slot.
- R7: The table byte at address a equals (a*29 + SEED) mod 256, with SEED defaulting to 0x3C.
- R8: While `enable_i` is 0, `sda_oe_o` is 0 from the next system clock on. Transmit-clock edges are ignored and the bit and byte positions hold. After re-enable, the next edge sends the bit that would have followed.
- R9: Edges that arrive with `enable_i` low during the start-up window do not count toward its 9 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Streamer enable from the mode arbiter |
| tclk_i | input | 1 | Asynchronous transmit clock |
| sda_o | output | 1 | Serial data value |
| sda_oe_o | output | 1 | Output-enable; line released when 0 |

## Verification
The bench builds the block with its default parameters: a 7-bit address, 8-bit bytes, a 9-edge start-up window and SEED 0x3C. With these values, a full pass of 128 bytes plus two more takes about 1180 transmit edges. That brings the address wrap and the table formula for every address within reach of a single run. Directed tests then freeze the stream in the middle of a byte and during the start-up window, and apply reset in the middle of the stream.

// File: rtl/id_tx_pkg.sv
package id_tx_pkg;
  typedef enum logic [0:0] {ST_INIT, ST_RUN} tx_state_e;
  localparam int unsigned ROM_STEP = 29;
endpackage

// File: rtl/id_tx_edge_sync.sv
module id_tx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // q[STAGES-1] is the synchronized level, q[STAGES] its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], async_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/id_tx_rom.sv
module id_tx_rom #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter logic [7:0]  SEED   = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  import id_tx_pkg::*;

  function automatic logic [DATA_W-1:0] table_byte(input logic [ADDR_W-1:0] a);
    int unsigned v;
    v = int'(a) * ROM_STEP + int'(SEED);
    return DATA_W'(v);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= table_byte(addr_i);
  end
endmodule

// File: rtl/id_tx_seq.sv
module id_tx_seq #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned INIT_EDGES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              enable_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sda_o,
  output logic              oe_o,
  output logic [$clog2(DATA_W+1)-1:0] bit_idx_o,
  output logic              running_o
);
  import id_tx_pkg::*;

  localparam int unsigned BIT_W  = $clog2(DATA_W + 1);
  localparam int unsigned INIT_W = $clog2(INIT_EDGES + 1);
  localparam logic [BIT_W-1:0]  NULL_IDX = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0]  TOP_IDX  = BIT_W'(DATA_W - 1);
  localparam logic [INIT_W-1:0] LAST_INIT = INIT_W'(INIT_EDGES - 1);

  tx_state_e          state_q;
  logic [INIT_W-1:0]  init_cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic               sda_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT;
      init_cnt_q <= '0;
      bit_q      <= '0;
      ptr_q      <= '0;
      sda_q      <= 1'b1;
      oe_q       <= 1'b0;
    end else if (!enable_i) begin
      sda_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (rise_i) begin
      unique case (state_q)
        ST_INIT: begin
          init_cnt_q <= init_cnt_q + 1'b1;
          if (init_cnt_q == LAST_INIT) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (bit_q == NULL_IDX) begin
            // release for the null slot; advancing ptr fetches the next byte
            sda_q <= 1'b1;
            oe_q  <= 1'b0;
            bit_q <= '0;
            ptr_q <= ptr_q + 1'b1;
          end else begin
            sda_q <= rd_data_i[TOP_IDX - bit_q];
            oe_q  <= 1'b1;
            bit_q <= bit_q + 1'b1;
          end
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_o     = sda_q;
  assign oe_o      = oe_q;
  assign bit_idx_o = bit_q;
  assign running_o = (state_q == ST_RUN);
endmodule

// File: rtl/id_tx_serializer.sv
module id_tx_serializer #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned INIT_EDGES = 9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  SEED       = 8'h3C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tclk_i,
  output logic sda_o,
  output logic sda_oe_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  logic              tclk_rise;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [BIT_W-1:0]  bit_idx;
  logic              running;

  id_tx_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (tclk_i),
    .rise_o  (tclk_rise)
  );

  id_tx_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) i_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (rd_addr),
    .data_o (rd_data)
  );

  id_tx_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_EDGES(INIT_EDGES)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (tclk_rise),
    .enable_i  (enable_i),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .sda_o     (sda_o),
    .oe_o      (sda_oe_o),
    .bit_idx_o (bit_idx),
    .running_o (running)
  );
endmodule

// File: rtl/id_tx_chk.sv
module id_tx_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic rise_i,
  input logic running_i,
  input logic [$clog2(DATA_W+1)-1:0] bit_idx_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic sda_i,
  input logic oe_i
);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0]  NULL_IDX = BIT_W'(DATA_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic step;
  assign step = enable_i && rise_i && running_i;

  a_r1_quiet_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> !oe_i);

  a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !rise_i) |=> ($stable(sda_i) && $stable(oe_i)));

  a_r4_data_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && bit_idx_i != NULL_IDX) |=> oe_i);

  a_r5_null_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && bit_idx_i == NULL_IDX) |=> (!oe_i && sda_i && bit_idx_i == '0));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && bit_idx_i == NULL_IDX && ptr_i == LAST_ADDR) |=> (ptr_i == '0));

  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && bit_idx_i == NULL_IDX && ptr_i != LAST_ADDR) |=> (ptr_i == $past(ptr_i) + 1'b1));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !oe_i);

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ($stable(ptr_i) && $stable(bit_idx_i) && $stable(running_i)));
endmodule

bind id_tx_serializer id_tx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .rise_i    (tclk_rise),
  .running_i (running),
  .bit_idx_i (bit_idx),
  .ptr_i     (rd_addr),
  .sda_i     (sda_o),
  .oe_i      (sda_oe_o)
);

// File: tb/test_id_tx_serializer.sv
`timescale 1ns/1ps
module test_id_tx_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic tclk = 1'b0;
  logic sda, oe;
  int n_checks = 0;
  int n_errors = 0;
  int e = 0;
  bit done = 0;

  always #10 clk = ~clk;

  id_tx_serializer i_id_tx_serializer (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .tclk_i(tclk),
    .sda_o(sda), .sda_oe_o(oe)
  );

  // edge number in [15:2], expected {oe,sda} in [1:0]
  localparam int N_VEC = 8;
  localparam logic [15:0] VEC [N_VEC] = '{
    {14'd1, 2'b01}, {14'd9, 2'b01}, {14'd10, 2'b10}, {14'd12, 2'b11},
    {14'd17, 2'b10}, {14'd18, 2'b01}, {14'd19, 2'b10}, {14'd20, 2'b11}
  };

  function automatic logic [1:0] exp_at(input int edge_n);
    int pos, bi, a;
    logic [7:0] b;
    if (edge_n <= 9) return 2'b01;
    pos = edge_n - 10;
    bi  = pos % 9;
    a   = (pos / 9) % 128;
    if (bi == 8) return 2'b01;
    b = 8'((a * 29 + 60) % 256);
    return {1'b1, b[7 - bi]};
  endfunction

  task automatic tclk_edge();
    @(posedge clk); #1 tclk = 1'b1;
    repeat (4) @(posedge clk); #1 tclk = 1'b0;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [1:0] exp);
    n_checks++;
    if ({oe, sda} !== exp) begin
      n_errors++;
      $display("FAIL %s: edge %0d got oe=%b sda=%b expected oe=%b sda=%b",
               req, e, oe, sda, exp[1], exp[0]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1; tclk = 1'b0; e = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin
    do_reset();
    check("R1 reset state", 2'b01);

    // table walk: R1 start-up window, R2 first MSB, R4 data, R5 null
    for (int i = 0; i < N_VEC; i++) begin
      while (e < int'(VEC[i][15:2])) begin tclk_edge(); e++; end
      check(e <= 9 ? "R1" : (e == 10 ? "R2" : (VEC[i][1] ? "R4" : "R5")), VEC[i][1:0]);
    end

    // full pass and wrap: R4 R5 R6 R7
    while (e < 9 + 9 * 130) begin
      tclk_edge(); e++;
      check("R6 R7 stream", exp_at(e));
    end

    // R8: freeze mid byte, then resume
    repeat (3) begin tclk_edge(); e++; check("R8 pre", exp_at(e)); end
    @(posedge clk); #1 en = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R8 release", 2'b01);
    for (int k = 0; k < 5; k++) begin tclk_edge(); check("R8 ignored edge", 2'b01); end
    @(posedge clk); #1 en = 1'b1;
    tclk_edge(); e++;
    check("R8 resume", exp_at(e));
    tclk_edge(); e++;
    check("R8 resume next", exp_at(e));

    // R3: no change without an edge
    repeat (20) @(posedge clk); #1;
    check("R3 hold", exp_at(e));

    // reset mid stream, then R9 freeze inside start-up window
    do_reset();
    check("R1 reset mid stream", 2'b01);
    repeat (4) begin tclk_edge(); e++; check("R1 window", 2'b01); end
    @(posedge clk); #1 en = 1'b0;
    for (int k = 0; k < 10; k++) tclk_edge();
    check("R9 frozen window", 2'b01);
    @(posedge clk); #1 en = 1'b1;
    repeat (5) begin tclk_edge(); e++; check("R9 window", 2'b01); end
    tclk_edge(); e++;
    check("R9 R2 first MSB", exp_at(e));
    repeat (3) begin tclk_edge(); e++; check("R9 R4 after window", exp_at(e)); end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule